// File: doc/BRIEF.md
# Flow-Table Essential Hazard Checker

This block holds a programmable next-state table for an asynchronous machine with one binary input and up to eight states. It decides whether that table is free of essential hazards. Software or a test sequencer loads the table one entry at a time, pulses a start strobe and waits for done. The block then visits every total state (present state, input value) in a fixed order. Each total state whose next-state entry points back to itself is used as a starting point.

From each stable starting point the block runs two experiments. First it flips the input once and follows the table until the machine comes to rest. Then it returns to the same start and flips the input three times, letting the machine settle after each flip. If the two resting states differ, the table has an essential hazard at that start. If a settling walk never comes to rest, an oscillation is flagged instead. Each table lookup costs one clock cycle, so the length of a run is exact and can be predicted. The result is held steady until the next run is started.

Top module: `ftab_hazard_chk`

## Requirements
- R1: While reset is high and after it is released, busy, done, pass, osc_err, fail_state and fail_in are all zero.
- R2: When busy is low and wr_en is high at a clock edge, the entry for (wr_state, wr_in) takes the value wr_next. A write in the same cycle as an accepted start is seen by that run.
- R3: A start seen while busy is low makes busy high and done low one cycle later. A start seen while busy is high has no effect on that run's results or length.
- R4: A write presented while busy is high leaves the table unchanged.
- R5: A total state (s, x) is stable when entry (s, x) equals s. An unstable total state is skipped and costs exactly one cycle.
- R6: Settling under input value v repeats, one lookup per cycle, cur = entry(cur, v) until the looked-up entry equals cur. A walk that needs up to 2**SW-1 moves completes normally.
- R7: From a stable start (s, x), the first walk settles under input !x. The second walk restarts at s and settles under !x, then under x, then under !x. If the two final states differ, the run ends with pass=0, osc_err=0, fail_state=s and fail_in=x.
- R8: Starts are scanned in ascending order of index 2*s+x, which means states ascending and input 0 before input 1. The run stops at the first failing start, and that start is the one reported.
- R9: If a walk's 2**SW-th lookup still finds an unstable entry, the run ends with osc_err=1, pass=0 and the current start in fail_state/fail_in.
- R10: If no start fails, the run ends with pass=1, osc_err=0, fail_state=0 and fail_in=0.
- R11: Busy stays high for exactly one cycle per scanned total state, plus one cycle per lookup in each walk. Done rises in the cycle that busy falls.
- R12: While done is high and no start is given, done and all result outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Table write strobe |
| wr_state | input | SW | Present state of the entry being written |
| wr_in | input | 1 | Input value of the entry being written |
| wr_next | input | SW | Next state stored in the entry |
| start | input | 1 | Begin a checking run |
| busy | output | 1 | Run in progress |
| done | output | 1 | Results valid |
| pass | output | 1 | Table free of essential hazards |
| osc_err | output | 1 | A settling walk failed to come to rest |
| fail_state | output | SW | State of the first failing start |
| fail_in | output | 1 | Input value of the first failing start |

## Verification
Two things can happen in the same cycle. A table write can coincide with the start strobe, and a write or another start can arrive in the middle of a run. The bench applies a write in the very cycle a start is taken and checks that the verdict matches the modified table. It also injects both a write and a fresh start partway through a run, and confirms from the verdict and the exact busy length that neither had any effect. Every expected verdict and cycle count comes from a behavioural model of the settling rules. That model is run over the example table, directed hazard, oscillation and long-chain tables, and a sweep of pseudo-random tables.

// File: rtl/ftab_pkg.sv
package ftab_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_WALK  = 2'd2
  } seq_st_e;

  // walk phases: one flip, then three flips (!x, x, !x)
  typedef enum logic [1:0] {
    PH_SINGLE = 2'd0,
    PH_TRI_A  = 2'd1,
    PH_TRI_B  = 2'd2,
    PH_TRI_C  = 2'd3
  } walk_ph_e;

endpackage

// File: rtl/ftab_mem.sv
module ftab_mem #(
  parameter int SW = 3
) (
  input  logic            clk,
  input  logic            we,
  input  logic [SW:0]     waddr,
  input  logic [SW-1:0]   wdata,
  input  logic [SW:0]     raddr,
  output logic [SW-1:0]   rdata
);

  localparam int DEPTH = 2 ** (SW + 1);

  logic [SW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // asynchronous read: distributed RAM, one lookup per cycle
  assign rdata = mem[raddr];

endmodule

// File: rtl/ftab_step.sv
module ftab_step #(
  parameter int SW = 3
) (
  input  logic [SW-1:0] cur,
  input  logic [SW-1:0] nxt,
  input  logic [SW-1:0] steps,
  output logic          settled,
  output logic          overrun
);

  localparam int          LAST_I    = (1 << SW) - 1;
  localparam logic [SW-1:0] LAST_MOVE = LAST_I[SW-1:0];

  always_comb begin
    settled = (nxt == cur);
    overrun = !settled && (steps == LAST_MOVE);
  end

endmodule

// File: rtl/ftab_seq.sv
module ftab_seq
  import ftab_pkg::*;
#(
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic [SW:0]   rd_addr,
  input  logic [SW-1:0] rd_data,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          osc_err,
  output logic [SW-1:0] fail_state,
  output logic          fail_in
);

  localparam int        AW       = SW + 1;
  localparam logic [AW-1:0] IDX_LAST = {AW{1'b1}};

  seq_st_e       st;
  walk_ph_e      ph;
  logic [AW-1:0] idx;
  logic [SW-1:0] cur;
  logic          inx;
  logic [SW-1:0] steps;
  logic [SW-1:0] first_fin;

  logic [SW-1:0] idx_s;
  logic          idx_x;
  logic          settled;
  logic          overrun;

  assign idx_s = idx[AW-1:1];
  assign idx_x = idx[0];

  assign rd_addr = (st == ST_CHECK) ? idx : {cur, inx};

  ftab_step #(.SW(SW)) u_step (
    .cur     (cur),
    .nxt     (rd_data),
    .steps   (steps),
    .settled (settled),
    .overrun (overrun)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      ph         <= PH_SINGLE;
      idx        <= '0;
      cur        <= '0;
      inx        <= 1'b0;
      steps      <= '0;
      first_fin  <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      pass       <= 1'b0;
      osc_err    <= 1'b0;
      fail_state <= '0;
      fail_in    <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            busy       <= 1'b1;
            done       <= 1'b0;
            pass       <= 1'b0;
            osc_err    <= 1'b0;
            fail_state <= '0;
            fail_in    <= 1'b0;
            idx        <= '0;
            st         <= ST_CHECK;
          end
        end

        ST_CHECK: begin
          if (rd_data == idx_s) begin
            cur   <= idx_s;
            inx   <= ~idx_x;
            ph    <= PH_SINGLE;
            steps <= '0;
            st    <= ST_WALK;
          end else if (idx == IDX_LAST) begin
            busy <= 1'b0;
            done <= 1'b1;
            pass <= 1'b1;
            st   <= ST_IDLE;
          end else begin
            idx <= idx + 1'b1;
          end
        end

        ST_WALK: begin
          if (settled) begin
            steps <= '0;
            unique case (ph)
              PH_SINGLE: begin
                first_fin <= cur;
                cur       <= idx_s;
                inx       <= ~idx_x;
                ph        <= PH_TRI_A;
              end
              PH_TRI_A: begin
                inx <= idx_x;
                ph  <= PH_TRI_B;
              end
              PH_TRI_B: begin
                inx <= ~idx_x;
                ph  <= PH_TRI_C;
              end
              PH_TRI_C: begin
                if (cur != first_fin) begin
                  busy       <= 1'b0;
                  done       <= 1'b1;
                  pass       <= 1'b0;
                  osc_err    <= 1'b0;
                  fail_state <= idx_s;
                  fail_in    <= idx_x;
                  st         <= ST_IDLE;
                end else if (idx == IDX_LAST) begin
                  busy <= 1'b0;
                  done <= 1'b1;
                  pass <= 1'b1;
                  st   <= ST_IDLE;
                end else begin
                  idx <= idx + 1'b1;
                  st  <= ST_CHECK;
                end
              end
              default: ph <= PH_SINGLE;
            endcase
          end else if (overrun) begin
            busy       <= 1'b0;
            done       <= 1'b1;
            pass       <= 1'b0;
            osc_err    <= 1'b1;
            fail_state <= idx_s;
            fail_in    <= idx_x;
            st         <= ST_IDLE;
          end else begin
            cur   <= rd_data;
            steps <= steps + 1'b1;
          end
        end

        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ftab_hazard_chk.sv
module ftab_hazard_chk #(
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_state,
  input  logic          wr_in,
  input  logic [SW-1:0] wr_next,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          osc_err,
  output logic [SW-1:0] fail_state,
  output logic          fail_in
);

  localparam int AW = SW + 1;

  logic [AW-1:0] rd_addr;
  logic [SW-1:0] rd_data;
  logic          we_gated;

  assign we_gated = wr_en && !busy;

  ftab_mem #(.SW(SW)) u_mem (
    .clk   (clk),
    .we    (we_gated),
    .waddr ({wr_state, wr_in}),
    .wdata (wr_next),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  ftab_seq #(.SW(SW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .busy       (busy),
    .done       (done),
    .pass       (pass),
    .osc_err    (osc_err),
    .fail_state (fail_state),
    .fail_in    (fail_in)
  );

endmodule

// File: rtl/ftab_hazard_chk_sva.sv
module ftab_hazard_chk_sva #(
  parameter int SW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          pass,
  input logic          osc_err,
  input logic [SW-1:0] fail_state,
  input logic          fail_in
);

  localparam int NST   = 2 ** SW;
  localparam int LIMIT = 2 * NST * (1 + 4 * NST);

  logic [15:0] run_len;

  always_ff @(posedge clk) begin
    if (rst)       run_len <= '0;
    else if (busy) run_len <= run_len + 16'd1;
    else           run_len <= '0;
  end

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(busy && done)); // R3

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && !done)); // R3

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(pass) && $stable(osc_err)
                          && $stable(fail_state) && $stable(fail_in))); // R12

  AST_OSC_NOT_PASS: assert property (@(posedge clk) disable iff (rst)
    (done && osc_err) |-> !pass); // R9

  AST_PASS_NO_LOC: assert property (@(posedge clk) disable iff (rst)
    (done && pass) |-> (fail_state == '0 && !fail_in && !osc_err)); // R10

  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done); // R11

  AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run_len < 16'(LIMIT))); // R11

endmodule

bind ftab_hazard_chk ftab_hazard_chk_sva #(.SW(SW)) u_sva (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .pass       (pass),
  .osc_err    (osc_err),
  .fail_state (fail_state),
  .fail_in    (fail_in)
);

// File: tb/ftab_hazard_chk_bench.sv
`timescale 1ns/1ps
module ftab_hazard_chk_bench;

  localparam int SW  = 3;
  localparam int NST = 8;
  localparam int NE  = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [SW-1:0] wr_state = '0;
  logic          wr_in = 1'b0;
  logic [SW-1:0] wr_next = '0;
  logic          start = 1'b0;
  logic          busy, done, pass, osc_err, fail_in;
  logic [SW-1:0] fail_state;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  int tab_q [NE];
  int lfsr = 32'h1ACE5;

  always #2.5 clk = ~clk;

  ftab_hazard_chk #(.SW(SW)) u_ftab_hazard_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_state(wr_state), .wr_in(wr_in),
    .wr_next(wr_next), .start(start), .busy(busy), .done(done), .pass(pass),
    .osc_err(osc_err), .fail_state(fail_state), .fail_in(fail_in)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural model of the settling rules
  task automatic model(output bit ps, output bit osc, output int fs, output int fi,
                       output int cyc);
    ps = 1; osc = 0; fs = 0; fi = 0; cyc = 0;
    for (int i = 0; i < NE; i++) begin
      int s;
      int x;
      int cur;
      int f1;
      bit bad;
      s = i / 2; x = i % 2; cur = s; f1 = 0; bad = 0;
      cyc++;
      if (tab_q[i] == s) begin
        for (int ph = 0; ph < 4 && !bad; ph++) begin
          int v;
          if (ph == 1) cur = s;
          v = (ph == 2) ? x : 1 - x;
          for (int k = 0; k < NST; k++) begin
            int nxt;
            cyc++;
            nxt = tab_q[cur * 2 + v];
            if (nxt == cur) break;
            if (k == NST - 1) begin bad = 1; osc = 1; break; end
            cur = nxt;
          end
          if (!bad && ph == 0) f1 = cur;
        end
        if (!bad && cur != f1) bad = 1;
        if (bad) begin ps = 0; fs = s; fi = x; return; end
      end
    end
  endtask

  task automatic put(input int s, input int x, input int v);
    wr_en = 1; wr_state = s[SW-1:0]; wr_in = x[0]; wr_next = v[SW-1:0];
    @(negedge clk);
    wr_en = 0;
    tab_q[s * 2 + x] = v;
  endtask

  task automatic load_self_rows(input int from);
    for (int s = from; s < NST; s++) begin
      put(s, 0, s);
      put(s, 1, s);
    end
  endtask

  // mode: 0 plain, 1 write (1,1)=3 with start, 2 poke write+start during busy
  task automatic run(input string req, input int mode);
    bit ps; bit osc; int fs; int fi; int cyc; int n;
    if (mode == 1) tab_q[3] = 3;
    model(ps, osc, fs, fi, cyc);
    start = 1;
    if (mode == 1) begin wr_en = 1; wr_state = 1; wr_in = 1; wr_next = 3; end
    @(negedge clk);
    start = 0; wr_en = 0;
    chk(busy && !done, "R3 start accepted", {busy, done}, 2);
    n = 0;
    while (busy && n < 5000) begin
      n++;
      if (mode == 2 && n == 3) begin
        start = 1; wr_en = 1; wr_state = 1; wr_in = 1; wr_next = 3;
      end else begin
        start = 0; wr_en = 0;
      end
      @(negedge clk);
    end
    start = 0; wr_en = 0;
    chk(done == 1, {req, " done"}, done, 1);
    chk(pass == ps, {req, " pass"}, pass, ps);
    chk(osc_err == osc, {req, " osc_err"}, osc_err, osc);
    chk(int'(fail_state) == fs, {req, " fail_state"}, fail_state, fs);
    chk(int'(fail_in) == fi, {req, " fail_in"}, fail_in, fi);
    chk(n == cyc, (mode == 2) ? "R3 busy length with stray start" : "R11 busy length", n, cyc);
    repeat (3) @(negedge clk);
    chk(done && pass == ps && osc_err == osc && int'(fail_state) == fs,
        "R12 results held", {done, pass, osc_err}, {1'b1, ps, osc});
  endtask

  task automatic load_hazard_tab();
    put(0, 0, 0); put(0, 1, 1);
    put(1, 0, 2); put(1, 1, 1);
    put(2, 0, 2); put(2, 1, 3);
    put(3, 0, 3); put(3, 1, 3);
    load_self_rows(4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !pass && !osc_err && fail_state == 0 && !fail_in,
        "R1 outputs during reset", {busy, done, pass, osc_err}, 0);
    rst = 0;
    @(negedge clk);
    chk(!busy && !done && !pass && !osc_err && fail_state == 0 && !fail_in,
        "R1 outputs after reset", {busy, done, pass, osc_err}, 0);

    // example table A..D = 0..3, hazard free
    put(0, 0, 0); put(0, 1, 1);
    put(1, 0, 2); put(1, 1, 3);
    put(2, 0, 2); put(2, 1, 3);
    put(3, 0, 0); put(3, 1, 3);
    load_self_rows(4);
    run("R10 example table", 0);

    // hazard at (0,0): one flip rests in 1, three flips rest in 3
    load_hazard_tab();
    run("R7 directed hazard", 0);

    // write during busy is ignored: result must still show the hazard
    run("R4 write while busy", 2);
    run("R4 table unchanged", 0);

    // write taken with start: (1,1)=3 removes the hazard
    load_hazard_tab();
    run("R2 write with start", 1);

    // no stable total state at all: each start costs one cycle
    for (int s = 0; s < NST; s++) begin
      put(s, 0, (s + 1) % NST);
      put(s, 1, (s + 2) % NST);
    end
    run("R5 all unstable", 0);

    // longest legal walk: chain 0->7 under input 1
    for (int s = 0; s < NST; s++) begin
      put(s, 0, s);
      put(s, 1, (s < NST - 1) ? s + 1 : s);
    end
    run("R6 longest chain", 0);

    // ring under input 1 never settles
    for (int s = 0; s < NST; s++) begin
      put(s, 0, s);
      put(s, 1, (s + 1) % NST);
    end
    run("R9 ring oscillation", 0);

    // pseudo-random sweep; first failure in scan order
    for (int t = 0; t < 40; t++) begin
      bit ps; bit osc; int fs; int fi; int cyc;
      for (int i = 0; i < NE; i++) begin
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
        if ((lfsr % 3) != 0) put(i / 2, i % 2, i / 2);
        else                 put(i / 2, i % 2, (lfsr >> 4) % NST);
      end
      model(ps, osc, fs, fi, cyc);
      run(osc ? "R9 sweep" : (ps ? "R10 sweep" : "R8 sweep"), 0);
    end

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule